// File: doc/BRIEF.md
# Banked Register File with Operand Collectors

This block stores the per-warp register state of a wide SIMD core in a set of single-ported banks and gathers the source operands of decoded instructions into collector entries. One bank row holds one named register of one warp across all lanes, so a single read returns a whole operand row. A decoded instruction takes a free collector entry with up to three source slots. Each enabled slot requests its row from the bank that owns it. A per-bank arbiter grants at most one access per cycle, so sources that land in the same bank are read over several cycles.

Writebacks use the same banks and take precedence over reads. A write also keeps buffered operands coherent. A collector slot that already holds the written register takes the new row in place. A slot whose read has not yet returned is sent back to request the register again. Once every enabled slot of an entry holds data, the entry offers the instruction to dispatch, and it is released on the dispatch handshake.

Top module: `opcol_regfile`

## Requirements
- R1: After reset, disp_valid is low, alloc_ready is high and every collector entry is free.
- R2: Register r of warp w lives in bank (r + w) mod NUM_BANKS. One row is LANES x LANE_W bits, and lane i occupies bits [i*LANE_W +: LANE_W].
- R3: Each bank serves at most one access per cycle. Counting the cycle in which the allocation is accepted as cycle 0, disp_valid is first high in cycle 2 + m, where m is the largest number of enabled sources that map to one bank. A grant returns data to its slot in the next cycle.
- R4: A write to a bank blocks every read grant on that bank in the same cycle, and each such cycle delays a waiting read by one cycle.
- R5: A read that is granted after a write returns the written row.
- R6: alloc_ready is high exactly when at least one collector entry is free. An accepted allocation captures the warp, the three source enables (bit s enables slot s) and the three register numbers (slot s at bits [s*REG_W +: REG_W]).
- R7: disp_valid is high only when every enabled slot of the offered entry holds data. The data of a disabled slot reads as zero. An instruction with no enabled source is offered in cycle 1. Slot s data is at disp_data[s*ROW_W +: ROW_W].
- R8: When disp_valid and disp_ready are both high at a clock edge, the offered entry is free from the next cycle on.
- R9: A write to a slot's warp and register while that slot waits for or holds an outstanding read leaves the slot not ready. The slot then reads again and receives the new row.
- R10: A write to a slot's warp and register after that slot holds data replaces the buffered row in place, and the slot stays ready.
- R11: Read requests to one bank and ready entries at dispatch are both served in round-robin order, so every waiting request is eventually served.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alloc_valid | input | 1 | Decoded instruction requests a collector entry |
| alloc_ready | output | 1 | A collector entry is free |
| alloc_warp | input | WARP_W | Warp of the instruction |
| alloc_src_en | input | 3 | Source slot enables |
| alloc_src_reg | input | 3*REG_W | Source register numbers |
| wr_en | input | 1 | Writeback valid |
| wr_warp | input | WARP_W | Writeback warp |
| wr_reg | input | REG_W | Writeback register number |
| wr_data | input | LANES*LANE_W | Writeback row |
| disp_valid | output | 1 | An entry with all operands is offered |
| disp_ready | input | 1 | Dispatch accepts the offered entry |
| disp_warp | output | WARP_W | Warp of the offered instruction |
| disp_src_en | output | 3 | Source enables of the offered instruction |
| disp_data | output | 3*LANES*LANE_W | Operand rows of the offered instruction |

## Verification
The assertions check in every cycle that no bank grants more than one request, that no read is granted in a bank being written, that every grant returns data to its slot in the following cycle, and that a dispatched entry becomes free. Latency as a function of how sources share banks, the values returned after writes, and the invalidate or refresh of buffered operands can only be shown by the bench's scenarios. The bench sweeps every register pair of every warp on a four-bank configuration and adds targeted write-collision, back-pressure and full-occupancy cases.

// File: rtl/opcol_pkg.sv
package opcol_pkg;

  localparam int SRC_PER_INSTR = 3;

  typedef enum logic [1:0] {
    SL_UNUSED = 2'd0,
    SL_WAIT   = 2'd1,
    SL_FLIGHT = 2'd2,
    SL_FULL   = 2'd3
  } slot_st_t;

  // Skewed placement: warps rotate their registers across the banks.
  function automatic int bank_of(int rnum, int warp, int nbanks);
    return (rnum + warp) % nbanks;
  endfunction

endpackage

// File: rtl/opcol_rr_arb.sv
module opcol_rr_arb #(
  parameter int N = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [N-1:0]  req,
  input  logic          advance,
  output logic [N-1:0]  gnt,
  output logic          any,
  output logic [IW-1:0] idx
);

  logic [IW-1:0] ptr;

  always_comb begin
    int j;
    gnt = '0;
    any = 1'b0;
    idx = '0;
    for (int i = 0; i < N; i++) begin
      j = int'(ptr) + i;
      if (j >= N) j = j - N;
      if (!any && req[j]) begin
        any    = 1'b1;
        gnt[j] = 1'b1;
        idx    = IW'(j);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr <= '0;
    end else if (advance && any) begin
      ptr <= (int'(idx) == N - 1) ? '0 : idx + 1'b1;
    end
  end

endmodule

// File: rtl/opcol_bank.sv
module opcol_bank #(
  parameter int DEPTH = 8,
  parameter int W     = 1024,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);

  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end

endmodule

// File: rtl/opcol_collector.sv
module opcol_collector
  import opcol_pkg::*;
#(
  parameter int NUM_BANKS = 16,
  parameter int WARP_W    = 2,
  parameter int REG_W     = 5,
  parameter int BANK_W    = 4,
  parameter int RA_W      = 3,
  parameter int ROW_W     = 1024,
  parameter int SRC       = SRC_PER_INSTR
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  alloc_go,
  input  logic [WARP_W-1:0]     alloc_warp,
  input  logic [SRC-1:0]        alloc_en,
  input  logic [SRC*REG_W-1:0]  alloc_reg,
  input  logic                  free_go,
  input  logic                  wr_en,
  input  logic [WARP_W-1:0]     wr_warp,
  input  logic [REG_W-1:0]      wr_reg,
  input  logic [ROW_W-1:0]      wr_data,
  input  logic [SRC-1:0]        slot_gnt,
  input  logic [SRC-1:0]        ret_valid,
  input  logic [SRC*ROW_W-1:0]  ret_data,
  output logic                  busy,
  output logic                  all_ready,
  output logic [WARP_W-1:0]     warp,
  output logic [SRC-1:0]        used,
  output logic [SRC-1:0]        slot_req,
  output logic [SRC*BANK_W-1:0] slot_bank,
  output logic [SRC*RA_W-1:0]   slot_row,
  output logic [SRC*ROW_W-1:0]  slot_data
);

  slot_st_t         st    [SRC];
  logic [REG_W-1:0] rnum  [SRC];
  logic [ROW_W-1:0] dat_q [SRC];
  logic [SRC-1:0]   hit;

  always_comb begin
    for (int s = 0; s < SRC; s++) begin
      hit[s] = busy && (st[s] != SL_UNUSED) && wr_en &&
               (wr_warp == warp) && (wr_reg == rnum[s]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      warp <= '0;
      used <= '0;
    end else if (alloc_go) begin
      busy <= 1'b1;
      warp <= alloc_warp;
      used <= alloc_en;
    end else if (free_go) begin
      busy <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    for (int s = 0; s < SRC; s++) begin
      if (rst) begin
        st[s]   <= SL_UNUSED;
        rnum[s] <= '0;
        dat_q[s] <= '0;
      end else if (alloc_go) begin
        st[s]    <= alloc_en[s] ? SL_WAIT : SL_UNUSED;
        rnum[s]  <= alloc_reg[s*REG_W +: REG_W];
        dat_q[s] <= '0;
      end else if (free_go) begin
        st[s] <= SL_UNUSED;
      end else if (hit[s]) begin
        if (st[s] == SL_FULL) dat_q[s] <= wr_data;
        else                  st[s]    <= SL_WAIT;
      end else if (st[s] == SL_WAIT && slot_gnt[s]) begin
        st[s] <= SL_FLIGHT;
      end else if (st[s] == SL_FLIGHT && ret_valid[s]) begin
        st[s]    <= SL_FULL;
        dat_q[s] <= ret_data[s*ROW_W +: ROW_W];
      end
    end
  end

  always_comb begin
    all_ready = busy;
    for (int s = 0; s < SRC; s++) begin
      slot_req[s] = (st[s] == SL_WAIT);
      if (st[s] == SL_WAIT || st[s] == SL_FLIGHT) all_ready = 1'b0;
      slot_bank[s*BANK_W +: BANK_W] =
        BANK_W'(bank_of(int'(rnum[s]), int'(warp), NUM_BANKS));
      slot_row[s*RA_W +: RA_W]   = {warp, rnum[s][REG_W-1:BANK_W]};
      slot_data[s*ROW_W +: ROW_W] = dat_q[s];
    end
  end

endmodule

// File: rtl/opcol_regfile.sv
module opcol_regfile
  import opcol_pkg::*;
#(
  parameter int NUM_BANKS = 16,
  parameter int NUM_WARPS = 4,
  parameter int NUM_REGS  = 32,
  parameter int LANES     = 32,
  parameter int LANE_W    = 32,
  parameter int NUM_COLL  = 4,
  localparam int SRC      = SRC_PER_INSTR,
  localparam int WARP_W   = $clog2(NUM_WARPS),
  localparam int REG_W    = $clog2(NUM_REGS),
  localparam int BANK_W   = $clog2(NUM_BANKS),
  localparam int ROW_W    = LANES * LANE_W,
  localparam int RA_W     = WARP_W + REG_W - BANK_W,
  localparam int DEPTH    = NUM_WARPS * NUM_REGS / NUM_BANKS,
  localparam int NSLOT    = NUM_COLL * SRC,
  localparam int SLOT_W   = $clog2(NSLOT),
  localparam int COLL_W   = $clog2(NUM_COLL)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 alloc_valid,
  output logic                 alloc_ready,
  input  logic [WARP_W-1:0]    alloc_warp,
  input  logic [SRC-1:0]       alloc_src_en,
  input  logic [SRC*REG_W-1:0] alloc_src_reg,
  input  logic                 wr_en,
  input  logic [WARP_W-1:0]    wr_warp,
  input  logic [REG_W-1:0]     wr_reg,
  input  logic [ROW_W-1:0]     wr_data,
  output logic                 disp_valid,
  input  logic                 disp_ready,
  output logic [WARP_W-1:0]    disp_warp,
  output logic [SRC-1:0]       disp_src_en,
  output logic [SRC*ROW_W-1:0] disp_data
);

  // collector side
  logic [NUM_COLL-1:0]                c_busy, c_ready, c_alloc, c_free, d_gnt;
  logic [NUM_COLL-1:0][WARP_W-1:0]    c_warp;
  logic [NUM_COLL-1:0][SRC-1:0]       c_used;
  logic [NUM_COLL-1:0][SRC*ROW_W-1:0] c_data;
  logic [COLL_W-1:0]                  d_idx;
  logic [COLL_W-1:0]                  free_idx;

  // slot side, flattened over all collectors
  logic [NSLOT-1:0]        s_req, s_gnt, s_ret;
  logic [NSLOT*BANK_W-1:0] s_bank;
  logic [NSLOT*RA_W-1:0]   s_row;
  logic [NSLOT*ROW_W-1:0]  s_ret_data;

  // bank side
  logic [NUM_BANKS-1:0][NSLOT-1:0]  bank_gnt;
  logic [NUM_BANKS-1:0]             bank_go, tag_v;
  logic [NUM_BANKS-1:0][SLOT_W-1:0] bank_idx, tag_i;
  logic [NUM_BANKS-1:0][ROW_W-1:0]  bank_rd;
  logic [BANK_W-1:0]                wr_bank;
  logic [RA_W-1:0]                  wr_row;

  assign wr_bank = BANK_W'(bank_of(int'(wr_reg), int'(wr_warp), NUM_BANKS));
  assign wr_row  = {wr_warp, wr_reg[REG_W-1:BANK_W]};

  // allocation: lowest free entry
  always_comb begin
    free_idx = '0;
    for (int c = NUM_COLL - 1; c >= 0; c--) begin
      if (!c_busy[c]) free_idx = COLL_W'(c);
    end
    alloc_ready = ~&c_busy;
    for (int c = 0; c < NUM_COLL; c++) begin
      c_alloc[c] = alloc_valid && alloc_ready && (free_idx == COLL_W'(c));
    end
  end

  genvar gc;
  generate
    for (gc = 0; gc < NUM_COLL; gc++) begin : g_coll
      opcol_collector #(
        .NUM_BANKS(NUM_BANKS), .WARP_W(WARP_W), .REG_W(REG_W),
        .BANK_W(BANK_W), .RA_W(RA_W), .ROW_W(ROW_W), .SRC(SRC)
      ) u_coll (
        .clk       (clk),
        .rst       (rst),
        .alloc_go  (c_alloc[gc]),
        .alloc_warp(alloc_warp),
        .alloc_en  (alloc_src_en),
        .alloc_reg (alloc_src_reg),
        .free_go   (c_free[gc]),
        .wr_en     (wr_en),
        .wr_warp   (wr_warp),
        .wr_reg    (wr_reg),
        .wr_data   (wr_data),
        .slot_gnt  (s_gnt[gc*SRC +: SRC]),
        .ret_valid (s_ret[gc*SRC +: SRC]),
        .ret_data  (s_ret_data[gc*SRC*ROW_W +: SRC*ROW_W]),
        .busy      (c_busy[gc]),
        .all_ready (c_ready[gc]),
        .warp      (c_warp[gc]),
        .used      (c_used[gc]),
        .slot_req  (s_req[gc*SRC +: SRC]),
        .slot_bank (s_bank[gc*SRC*BANK_W +: SRC*BANK_W]),
        .slot_row  (s_row[gc*SRC*RA_W +: SRC*RA_W]),
        .slot_data (c_data[gc])
      );
    end
  endgenerate

  genvar gb;
  generate
    for (gb = 0; gb < NUM_BANKS; gb++) begin : g_bank
      logic [NSLOT-1:0] breq;
      logic             wr_here;
      logic [RA_W-1:0]  raddr;

      assign wr_here = wr_en && (wr_bank == BANK_W'(gb));

      // a write to this bank masks every read request for the cycle
      always_comb begin
        for (int k = 0; k < NSLOT; k++) begin
          breq[k] = s_req[k] && !wr_here &&
                    (s_bank[k*BANK_W +: BANK_W] == BANK_W'(gb));
        end
      end

      opcol_rr_arb #(.N(NSLOT)) u_arb (
        .clk    (clk),
        .rst    (rst),
        .req    (breq),
        .advance(1'b1),
        .gnt    (bank_gnt[gb]),
        .any    (bank_go[gb]),
        .idx    (bank_idx[gb])
      );

      assign raddr = s_row[bank_idx[gb]*RA_W +: RA_W];

      opcol_bank #(.DEPTH(DEPTH), .W(ROW_W)) u_bank (
        .clk  (clk),
        .we   (wr_here),
        .waddr(wr_row),
        .wdata(wr_data),
        .re   (bank_go[gb]),
        .raddr(raddr),
        .rdata(bank_rd[gb])
      );
    end
  endgenerate

  // return tags follow the synchronous bank read by one cycle
  always_ff @(posedge clk) begin
    if (rst) begin
      tag_v <= '0;
      tag_i <= '0;
    end else begin
      tag_v <= bank_go;
      tag_i <= bank_idx;
    end
  end

  always_comb begin
    s_gnt = '0;
    for (int b = 0; b < NUM_BANKS; b++) s_gnt = s_gnt | bank_gnt[b];
  end

  always_comb begin
    logic [BANK_W-1:0] b;
    for (int k = 0; k < NSLOT; k++) begin
      b = s_bank[k*BANK_W +: BANK_W];
      s_ret[k] = tag_v[b] && (tag_i[b] == SLOT_W'(k));
      s_ret_data[k*ROW_W +: ROW_W] = bank_rd[b];
    end
  end

  // dispatch: round-robin among complete entries
  opcol_rr_arb #(.N(NUM_COLL)) u_disp (
    .clk    (clk),
    .rst    (rst),
    .req    (c_ready),
    .advance(disp_ready),
    .gnt    (d_gnt),
    .any    (disp_valid),
    .idx    (d_idx)
  );

  assign c_free      = d_gnt & {NUM_COLL{disp_ready}};
  assign disp_warp   = c_warp[d_idx];
  assign disp_src_en = c_used[d_idx];
  assign disp_data   = c_data[d_idx];

endmodule

// File: rtl/opcol_checker.sv
module opcol_checker #(
  parameter int NUM_BANKS = 16,
  parameter int NSLOT     = 12,
  parameter int NUM_COLL  = 4,
  localparam int BANK_W   = $clog2(NUM_BANKS),
  localparam int COLL_W   = $clog2(NUM_COLL)
) (
  input logic                       clk,
  input logic                       rst,
  input logic [NUM_BANKS*NSLOT-1:0] bank_gnt,
  input logic [NUM_BANKS-1:0]       bank_go,
  input logic                       wr_en,
  input logic [BANK_W-1:0]          wr_bank,
  input logic [NSLOT-1:0]           s_gnt,
  input logic [NSLOT-1:0]           s_ret,
  input logic                       disp_valid,
  input logic                       disp_ready,
  input logic [COLL_W-1:0]          d_idx,
  input logic [NUM_COLL-1:0]        c_busy
);

  genvar gb;
  generate
    for (gb = 0; gb < NUM_BANKS; gb++) begin : g_b
      assert_one_grant_per_bank_R3: assert property (@(posedge clk) disable iff (rst)
        $onehot0(bank_gnt[gb*NSLOT +: NSLOT]));
    end
  endgenerate

  genvar gk;
  generate
    for (gk = 0; gk < NSLOT; gk++) begin : g_k
      assert_grant_returns_R3: assert property (@(posedge clk) disable iff (rst)
        s_gnt[gk] |=> s_ret[gk]);
    end
  endgenerate

  assert_write_blocks_read_R4: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> !bank_go[wr_bank]);

  assert_dispatch_frees_R8: assert property (@(posedge clk) disable iff (rst)
    (disp_valid && disp_ready) |=> !c_busy[$past(d_idx)]);

endmodule

bind opcol_regfile opcol_checker #(
  .NUM_BANKS(NUM_BANKS), .NSLOT(NSLOT), .NUM_COLL(NUM_COLL)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .bank_gnt  (bank_gnt),
  .bank_go   (bank_go),
  .wr_en     (wr_en),
  .wr_bank   (wr_bank),
  .s_gnt     (s_gnt),
  .s_ret     (s_ret),
  .disp_valid(disp_valid),
  .disp_ready(disp_ready),
  .d_idx     (d_idx),
  .c_busy    (c_busy)
);

// File: tb/opcol_regfile_tb.sv
module opcol_regfile_tb;

  localparam int NB = 4, NW = 4, NR = 8, LN = 2, LWD = 8, NC = 2;
  localparam int RW = LN * LWD;
  localparam int WW = $clog2(NW), RGW = $clog2(NR);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic alloc_valid = 1'b0;
  logic alloc_ready;
  logic [WW-1:0] alloc_warp = '0;
  logic [2:0] alloc_src_en = '0;
  logic [3*RGW-1:0] alloc_src_reg = '0;
  logic wr_en = 1'b0;
  logic [WW-1:0] wr_warp = '0;
  logic [RGW-1:0] wr_reg = '0;
  logic [RW-1:0] wr_data = '0;
  logic disp_valid;
  logic disp_ready = 1'b1;
  logic [WW-1:0] disp_warp;
  logic [2:0] disp_src_en;
  logic [3*RW-1:0] disp_data;

  int nchk = 0, nerr = 0, wcount = 0;
  logic [RW-1:0] shadow [NW][NR];

  always #2.5 clk = ~clk;

  opcol_regfile #(.NUM_BANKS(NB), .NUM_WARPS(NW), .NUM_REGS(NR),
                  .LANES(LN), .LANE_W(LWD), .NUM_COLL(NC)) u_dut (.*);

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [RW-1:0] next_val();
    wcount++;
    return RW'(16'h5A00 + wcount * 16'h0137);
  endfunction

  task automatic drive_write(input int w, input int r, input logic [RW-1:0] v);
    wr_en = 1'b1; wr_warp = WW'(w); wr_reg = RGW'(r); wr_data = v;
    shadow[w][r] = v;
  endtask

  task automatic start_alloc(input int w, input logic [2:0] en, input int r0, input int r1, input int r2);
    check("R6 alloc_ready before allocation", 64'(alloc_ready), 64'd1);
    alloc_valid = 1'b1; alloc_warp = WW'(w); alloc_src_en = en;
    alloc_src_reg = {RGW'(r2), RGW'(r1), RGW'(r0)};
    @(negedge clk);
    alloc_valid = 1'b0;
  endtask

  // Allocates, optionally writes register wr_r of warp w in cycles lo..hi,
  // waits for the offer and checks its cycle and contents.
  task automatic run_case(input int w, input logic [2:0] en, input int r0, input int r1, input int r2,
                          input int wr_r, input int lo, input int hi, input int exp_k, input string tag);
    int k;
    int rr [3];
    rr[0] = r0; rr[1] = r1; rr[2] = r2;
    start_alloc(w, en, r0, r1, r2);
    k = 1;
    while (!disp_valid && k < 40) begin
      if (k >= lo && k <= hi) drive_write(w, wr_r, next_val());
      else wr_en = 1'b0;
      @(negedge clk);
      k++;
    end
    wr_en = 1'b0;
    check({tag, " offer cycle"}, 64'(k), 64'(exp_k));
    check({tag, " R6 warp"}, 64'(disp_warp), 64'(w));
    check({tag, " R6 enables"}, 64'(disp_src_en), 64'(en));
    for (int s = 0; s < 3; s++) begin
      check({tag, " R7 slot data"}, 64'(disp_data[s*RW +: RW]),
            en[s] ? 64'(shadow[w][rr[s]]) : 64'd0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check("R1 disp_valid after reset", 64'(disp_valid), 64'd0);
    check("R1 alloc_ready after reset", 64'(alloc_ready), 64'd1);

    // preload every row, then R7 zero-source instruction is offered in cycle 1
    for (int w = 0; w < NW; w++) begin
      for (int r = 0; r < NR; r++) begin
        drive_write(w, r, RW'(w * 64 + r * 5 + 3));
        @(negedge clk);
      end
    end
    wr_en = 1'b0;
    run_case(0, 3'b000, 0, 0, 0, 0, 1, 0, 1, "R7 no-source");

    // R2/R3 sweep: every register pair of every warp, mixed enables
    for (int w = 0; w < NW; w++) begin
      for (int r0 = 0; r0 < NR; r0++) begin
        for (int r1 = 0; r1 < NR; r1++) begin
          logic [2:0] en;
          int r2, m;
          int cnt [NB];
          en = 3'((r0 + r1 + w) % 8);
          r2 = (r0 * 3 + r1 + 1) % NR;
          for (int b = 0; b < NB; b++) cnt[b] = 0;
          if (en[0]) cnt[(r0 + w) % NB]++;
          if (en[1]) cnt[(r1 + w) % NB]++;
          if (en[2]) cnt[(r2 + w) % NB]++;
          m = 0;
          for (int b = 0; b < NB; b++) if (cnt[b] > m) m = cnt[b];
          run_case(w, en, r0, r1, r2, 0, 1, 0, (m == 0) ? 1 : m + 2, "R2 R3 sweep");
        end
      end
    end

    // R4: writes to r6 of warp 1 (same bank as r2) in cycles 1..3 hold off the read
    run_case(1, 3'b001, 2, 0, 0, 6, 1, 3, 6, "R4 write priority");
    // R5: the written row is what a later read returns
    run_case(1, 3'b001, 6, 0, 0, 0, 1, 0, 3, "R5 read after write");
    // R9: write while the read is in flight (cycle 2) forces a re-read
    run_case(2, 3'b001, 5, 0, 0, 5, 2, 2, 5, "R9 in-flight hit");
    // R9: write while the slot is still waiting (cycle 1)
    run_case(2, 3'b001, 3, 0, 0, 3, 1, 1, 4, "R9 waiting hit");

    // R10: refresh of a ready slot under back-pressure, then R8 release
    @(negedge clk);
    disp_ready = 1'b0;
    start_alloc(3, 3'b001, 1, 0, 0);
    repeat (3) @(negedge clk);
    check("R10 offered before write", 64'(disp_valid), 64'd1);
    drive_write(3, 1, next_val());
    @(negedge clk);
    wr_en = 1'b0;
    check("R10 still offered", 64'(disp_valid), 64'd1);
    check("R10 refreshed data", 64'(disp_data[RW-1:0]), 64'(shadow[3][1]));
    disp_ready = 1'b1;
    @(negedge clk);
    check("R8 entry released", 64'(disp_valid), 64'd0);
    check("R8 alloc_ready after release", 64'(alloc_ready), 64'd1);

    // R6/R11: both entries on bank 0, no free entry, both served
    disp_ready = 1'b0;
    start_alloc(0, 3'b111, 0, 4, 0);
    start_alloc(0, 3'b001, 4, 0, 0);
    check("R6 alloc_ready when full", 64'(alloc_ready), 64'd0);
    repeat (8) @(negedge clk);
    check("R11 offer pending", 64'(disp_valid), 64'd1);
    disp_ready = 1'b1;
    begin
      logic saw_a, saw_b;
      saw_a = 1'b0; saw_b = 1'b0;
      repeat (4) begin
        if (disp_valid) begin
          if (disp_src_en == 3'b111) begin
            saw_a = 1'b1;
            check("R11 entry A data", 64'(disp_data),
                  64'({shadow[0][0], shadow[0][4], shadow[0][0]}));
          end else begin
            saw_b = 1'b1;
            check("R11 entry B data", 64'(disp_data), 64'(shadow[0][4]));
          end
        end
        @(negedge clk);
      end
      check("R11 entry A dispatched", 64'(saw_a), 64'd1);
      check("R11 entry B dispatched", 64'(saw_b), 64'd1);
    end
    check("R8 all free", 64'(alloc_ready), 64'd1);
    check("R8 nothing offered", 64'(disp_valid), 64'd0);

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

endmodule